// File: doc/BRIEF.md
# Byte Parity Guard for SRAM Banks

This block sits on the data path between a request front-end and an SRAM sequencer. On the write path it adds one parity bit to every data byte, so that the sequencer stores each bit next to its byte. On the read path it takes each returned beat, which carries the data, the stored parity bits and the byte enables. It recomputes parity for each byte, compares it with the stored bit, and marks the beat for an error (slave-error) response when an enabled byte disagrees. A single mode input selects no parity, even parity or odd parity for every bank at once. A parameter mask picks which banks are SRAM-type, and only those banks take part in parity.

For each bank, a capture register latches the address of the first failing beat and sets a sticky valid flag. Software reads these registers through a plain select/read port and clears them with a per-bank clear strobe.

Both data paths are valid/ready streams that pass straight through the block with no storage. A beat moves forward when its valid is high, and the upstream ready simply mirrors the downstream ready. A beat is accepted only in a cycle where valid and ready are both high. While ready is low, the upstream side must hold the beat steady, and nothing in the block changes state. The side fields (bank, address, data, byte enables) pass through unchanged.

Top module: `byte_parity_guard`

## Requirements
- R1: In even mode (`par_mode` = 1) each write parity bit `wr_out_par[i]` makes the count of ones across byte i (`wr_out_data[8i+7:8i]`) plus that bit even. In odd mode (`par_mode` = 2) it makes that count odd.
- R2: When `par_mode` is 0 or 3 (no parity), every write parity bit is 0, `rd_out_err` stays low, and no capture register is loaded.
- R3: For a bank whose bit in `SRAM_BANKS` is 0 (default: bank 3), write parity bits are 0 and read beats never raise `rd_out_err`, in every mode.
- R4: On a read beat, `rd_out_err` is 1 in the same cycle when any enabled byte's recomputed parity differs from its stored bit `rd_in_par[i]`. `rd_out_data` always equals `rd_in_data`.
- R5: A parity mismatch on a byte whose enable `rd_in_be[i]` is 0 is ignored.
- R6: When an erroring read beat is accepted (`rd_in_valid` and `rd_out_ready` both high), the capture register of that beat's bank, if empty, loads `rd_in_addr` and sets its valid flag. The result is visible on the read port from the next cycle. Other banks are untouched.
- R7: A capture register that already holds an error keeps its first address when later errors hit the same bank.
- R8: A pulse on `err_clr` clears the valid flag of bank `err_clr_bank`. If an erroring beat for that same bank is accepted in the same cycle, the new address is loaded and the flag stays set.
- R9: The streams carry no storage: `wr_out_valid`/`rd_out_valid` follow the input valids, `wr_in_ready`/`rd_in_ready` follow the output readies, and an erroring beat presented while `rd_out_ready` is 0 loads no capture register.
- R10: After reset every capture register reads valid 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| wr_in_valid | input | 1 | Write beat valid from front-end |
| wr_in_ready | output | 1 | Write beat ready to front-end |
| wr_in_bank | input | BANK_W | Target bank of write beat |
| wr_in_addr | input | ADDR_W | Write address |
| wr_in_data | input | 8*DATA_BYTES | Write data |
| wr_in_be | input | DATA_BYTES | Write byte enables |
| wr_out_valid | output | 1 | Write beat valid to sequencer |
| wr_out_ready | input | 1 | Write beat ready from sequencer |
| wr_out_bank | output | BANK_W | Bank, passed through |
| wr_out_addr | output | ADDR_W | Address, passed through |
| wr_out_data | output | 8*DATA_BYTES | Data, passed through |
| wr_out_be | output | DATA_BYTES | Byte enables, passed through |
| wr_out_par | output | DATA_BYTES | One parity bit per byte |
| rd_in_valid | input | 1 | Read return beat valid from sequencer |
| rd_in_ready | output | 1 | Read return beat ready to sequencer |
| rd_in_bank | input | BANK_W | Bank of returned beat |
| rd_in_addr | input | ADDR_W | Address of returned beat |
| rd_in_data | input | 8*DATA_BYTES | Returned data |
| rd_in_par | input | DATA_BYTES | Stored parity bits |
| rd_in_be | input | DATA_BYTES | Byte lanes in use for this beat |
| rd_out_valid | output | 1 | Read beat valid to front-end |
| rd_out_ready | input | 1 | Read beat ready from front-end |
| rd_out_data | output | 8*DATA_BYTES | Read data, passed through |
| rd_out_err | output | 1 | 1 requests a slave-error response for the beat |
| err_sel | input | BANK_W | Bank selected on the capture read port |
| err_rd_valid | output | 1 | Sticky flag of the selected bank |
| err_rd_addr | output | ADDR_W | Captured address of the selected bank |
| err_clr | input | 1 | Clear strobe |
| err_clr_bank | input | BANK_W | Bank cleared by the strobe |

## Verification
The bench aims at a single wrong parity bit on the lowest lane, and at a wrong bit on a lane whose enable is off. A checker that ignored byte enables would flag the masked case, and one that dropped the lowest lane would miss the real error. It also checks that even mode and odd mode produce opposite bits for an all-zero word, which catches a swapped polarity, and that mode 3 and a non-SRAM bank both stay silent. For capture, it tests a second error in a full bank, which exposes an overwrite, and a clear that lands in the same cycle as a new error, which exposes a wrong priority. It also presents an error beat with ready held low, which exposes a design that captures before the beat is accepted.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_e;
endpackage

// File: rtl/bpar_gen.sv
module bpar_gen
  import bpar_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  par_mode_e             mode_i,
  input  logic [8*NBYTES-1:0]   data_i,
  output logic [NBYTES-1:0]     par_o
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic ones_odd;
    assign ones_odd = ^data_i[8*i +: 8];
    assign par_o[i] = (mode_i == PAR_EVEN) ? ones_odd :
                      (mode_i == PAR_ODD)  ? ~ones_odd : 1'b0;
  end
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
  import bpar_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  par_mode_e             mode_i,
  input  logic [8*NBYTES-1:0]   data_i,
  input  logic [NBYTES-1:0]     par_i,
  input  logic [NBYTES-1:0]     be_i,
  output logic                  err_o
);
  logic [NBYTES-1:0] expect_par;
  logic [NBYTES-1:0] lane_bad;
  logic              active;

  bpar_gen #(.NBYTES(NBYTES)) u_regen (
    .mode_i (mode_i),
    .data_i (data_i),
    .par_o  (expect_par)
  );

  assign active   = (mode_i == PAR_EVEN) || (mode_i == PAR_ODD);
  assign lane_bad = (expect_par ^ par_i) & be_i;
  assign err_o    = active && (|lane_bad);
endmodule

// File: rtl/bpar_errbank.sv
module bpar_errbank #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (clr_i) valid_q <= 1'b0;
      if (cap_i && (!valid_q || clr_i)) begin
        valid_q <= 1'b1;
        addr_q  <= addr_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  // R7: a held error survives later captures
  assert_first_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr_i) |=> (valid_q && $stable(addr_q)));

  // R6: an empty register takes the offered address
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !valid_q) |=> (valid_q && addr_q == $past(addr_i)));

  // R8: clear without capture empties the register
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cap_i) |=> !valid_q);
endmodule

// File: rtl/byte_parity_guard.sv
module byte_parity_guard
  import bpar_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int NUM_BANKS  = 4,
  parameter logic [NUM_BANKS-1:0] SRAM_BANKS = 4'b0111,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            par_mode,
  input  logic                  wr_in_valid,
  output logic                  wr_in_ready,
  input  logic [BANK_W-1:0]     wr_in_bank,
  input  logic [ADDR_W-1:0]     wr_in_addr,
  input  logic [DATA_W-1:0]     wr_in_data,
  input  logic [DATA_BYTES-1:0] wr_in_be,
  output logic                  wr_out_valid,
  input  logic                  wr_out_ready,
  output logic [BANK_W-1:0]     wr_out_bank,
  output logic [ADDR_W-1:0]     wr_out_addr,
  output logic [DATA_W-1:0]     wr_out_data,
  output logic [DATA_BYTES-1:0] wr_out_be,
  output logic [DATA_BYTES-1:0] wr_out_par,
  input  logic                  rd_in_valid,
  output logic                  rd_in_ready,
  input  logic [BANK_W-1:0]     rd_in_bank,
  input  logic [ADDR_W-1:0]     rd_in_addr,
  input  logic [DATA_W-1:0]     rd_in_data,
  input  logic [DATA_BYTES-1:0] rd_in_par,
  input  logic [DATA_BYTES-1:0] rd_in_be,
  output logic                  rd_out_valid,
  input  logic                  rd_out_ready,
  output logic [DATA_W-1:0]     rd_out_data,
  output logic                  rd_out_err,
  input  logic [BANK_W-1:0]     err_sel,
  output logic                  err_rd_valid,
  output logic [ADDR_W-1:0]     err_rd_addr,
  input  logic                  err_clr,
  input  logic [BANK_W-1:0]     err_clr_bank
);
  par_mode_e mode;
  par_mode_e wr_mode;
  par_mode_e rd_mode;
  logic      rd_accept;
  logic      chk_err;

  assign mode    = par_mode_e'(par_mode);
  assign wr_mode = SRAM_BANKS[wr_in_bank] ? mode : PAR_NONE;
  assign rd_mode = SRAM_BANKS[rd_in_bank] ? mode : PAR_NONE;

  // Write stream: pure pass-through plus parity lanes
  assign wr_out_valid = wr_in_valid;
  assign wr_in_ready  = wr_out_ready;
  assign wr_out_bank  = wr_in_bank;
  assign wr_out_addr  = wr_in_addr;
  assign wr_out_data  = wr_in_data;
  assign wr_out_be    = wr_in_be;

  bpar_gen #(.NBYTES(DATA_BYTES)) u_gen (
    .mode_i (wr_mode),
    .data_i (wr_in_data),
    .par_o  (wr_out_par)
  );

  // Read stream: pass-through plus check
  assign rd_out_valid = rd_in_valid;
  assign rd_in_ready  = rd_out_ready;
  assign rd_out_data  = rd_in_data;

  bpar_chk #(.NBYTES(DATA_BYTES)) u_chk (
    .mode_i (rd_mode),
    .data_i (rd_in_data),
    .par_i  (rd_in_par),
    .be_i   (rd_in_be),
    .err_o  (chk_err)
  );

  assign rd_out_err = chk_err;
  assign rd_accept  = rd_in_valid && rd_out_ready;

  // Per-bank error capture
  logic              bank_valid [NUM_BANKS];
  logic [ADDR_W-1:0] bank_addr  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic cap;
    logic clr;
    assign cap = rd_accept && chk_err && (rd_in_bank == BANK_W'(b));
    assign clr = err_clr && (err_clr_bank == BANK_W'(b));
    bpar_errbank #(.ADDR_W(ADDR_W)) u_errbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap),
      .addr_i  (rd_in_addr),
      .clr_i   (clr),
      .valid_o (bank_valid[b]),
      .addr_o  (bank_addr[b])
    );
  end

  assign err_rd_valid = bank_valid[err_sel];
  assign err_rd_addr  = bank_addr[err_sel];

  // R1: generated bits obey the selected polarity on every lane
  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_sva_lane
    assert_par_polarity_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (SRAM_BANKS[wr_in_bank] && (par_mode == 2'd1 || par_mode == 2'd2)) |->
        ((^{wr_out_data[8*g +: 8], wr_out_par[g]}) == (par_mode == 2'd2)));
  end

  // R2: no-parity modes stay silent
  assert_none_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode == 2'd0 || par_mode == 2'd3) |-> (!rd_out_err && wr_out_par == '0));

  // R3: banks outside the SRAM mask never flag
  assert_nonsram_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !SRAM_BANKS[rd_in_bank] |-> !rd_out_err);

  // R5: an error needs at least one enabled lane
  assert_err_needs_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_err |-> (|rd_in_be));

  // R9: a beat held back by ready leaves the selected register unchanged
  assert_no_capture_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_out_ready && !err_clr && $stable(err_sel)) |=> $stable(err_rd_valid));
endmodule

// File: tb/byte_parity_guard_tb.sv
module byte_parity_guard_tb;
  localparam int NB = 4;
  localparam int AW = 16;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  bank;
    logic [31:0] data;
    logic [3:0]  par;
    logic [3:0]  be;
    logic [3:0]  wpar;
    logic        err;
  } vec_t;

  // Bytes: 01030F07 -> ones 1,2,4,3 ; FF80AA11 -> ones 8,1,4,2
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 32'h00000000, 4'b0000, 4'hF, 4'b0000, 1'b0},
    '{2'd2, 2'd0, 32'h00000000, 4'b1111, 4'hF, 4'b1111, 1'b0},
    '{2'd2, 2'd1, 32'h00000000, 4'b0000, 4'hF, 4'b1111, 1'b1},
    '{2'd1, 2'd1, 32'h01030F07, 4'b1001, 4'hF, 4'b1001, 1'b0},
    '{2'd1, 2'd2, 32'h01030F07, 4'b1000, 4'hF, 4'b1001, 1'b1},
    '{2'd1, 2'd2, 32'h01030F07, 4'b1000, 4'hE, 4'b1001, 1'b0}, // R5 masked lane 0
    '{2'd2, 2'd0, 32'hFF80AA11, 4'b1011, 4'hF, 4'b1011, 1'b0},
    '{2'd2, 2'd0, 32'hFF80AA11, 4'b0011, 4'h7, 4'b1011, 1'b0}, // R5 masked lane 3
    '{2'd2, 2'd0, 32'hFF80AA11, 4'b0011, 4'h8, 4'b1011, 1'b1},
    '{2'd0, 2'd0, 32'hFF80AA11, 4'b1111, 4'hF, 4'b0000, 1'b0}, // R2 none
    '{2'd3, 2'd1, 32'h01030F07, 4'b0000, 4'hF, 4'b0000, 1'b0}, // R2 mode 3
    '{2'd1, 2'd3, 32'h01030F07, 4'b0000, 4'hF, 4'b0000, 1'b0}, // R3 non-SRAM
    '{2'd2, 2'd3, 32'h00000000, 4'b0000, 4'hF, 4'b0000, 1'b0}  // R3 non-SRAM
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] par_mode = '0;
  logic wr_in_valid = 1'b0, wr_in_ready, wr_out_valid, wr_out_ready = 1'b0;
  logic [1:0] wr_in_bank = '0, wr_out_bank;
  logic [AW-1:0] wr_in_addr = '0, wr_out_addr;
  logic [31:0] wr_in_data = '0, wr_out_data;
  logic [NB-1:0] wr_in_be = '0, wr_out_be, wr_out_par;
  logic rd_in_valid = 1'b0, rd_in_ready, rd_out_valid, rd_out_ready = 1'b0;
  logic [1:0] rd_in_bank = '0;
  logic [AW-1:0] rd_in_addr = '0;
  logic [31:0] rd_in_data = '0, rd_out_data;
  logic [NB-1:0] rd_in_par = '0, rd_in_be = '0;
  logic rd_out_err;
  logic [1:0] err_sel = '0, err_clr_bank = '0;
  logic err_rd_valid;
  logic [AW-1:0] err_rd_addr;
  logic err_clr = 1'b0;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_parity_guard u_dut (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready), .wr_in_bank(wr_in_bank),
    .wr_in_addr(wr_in_addr), .wr_in_data(wr_in_data), .wr_in_be(wr_in_be),
    .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready), .wr_out_bank(wr_out_bank),
    .wr_out_addr(wr_out_addr), .wr_out_data(wr_out_data), .wr_out_be(wr_out_be),
    .wr_out_par(wr_out_par),
    .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready), .rd_in_bank(rd_in_bank),
    .rd_in_addr(rd_in_addr), .rd_in_data(rd_in_data), .rd_in_par(rd_in_par),
    .rd_in_be(rd_in_be), .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready),
    .rd_out_data(rd_out_data), .rd_out_err(rd_out_err),
    .err_sel(err_sel), .err_rd_valid(err_rd_valid), .err_rd_addr(err_rd_addr),
    .err_clr(err_clr), .err_clr_bank(err_clr_bank)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic peek_bank(string req, logic [1:0] b, logic v, logic [AW-1:0] a);
    err_sel = b;
    #1;
    check(req, 32'(err_rd_valid), 32'(v));
    check(req, 32'(err_rd_addr), 32'(a));
  endtask

  // Presents an erroring read beat (mode even, lane 0 wrong) for one edge
  task automatic err_beat(logic [1:0] b, logic [AW-1:0] a, logic rdy);
    @(negedge clk);
    rd_in_valid = 1'b1; rd_in_bank = b; rd_in_addr = a;
    rd_in_data = 32'h01030F07; rd_in_par = 4'b1000; rd_in_be = 4'hF;
    rd_out_ready = rdy;
    @(negedge clk);
    rd_in_valid = 1'b0; rd_out_ready = 1'b0; err_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state of every capture register
    for (int b = 0; b < 4; b++) peek_bank("R10", 2'(b), 1'b0, '0);

    // Vector table: write parity (R1) and read check (R4); rows tagged R2/R3/R5
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      par_mode = VECS[i].mode;
      wr_in_valid = 1'b1; wr_in_bank = VECS[i].bank; wr_in_data = VECS[i].data;
      wr_in_be = 4'hF; wr_in_addr = 16'(i);
      rd_in_valid = 1'b1; rd_in_bank = VECS[i].bank; rd_in_data = VECS[i].data;
      rd_in_par = VECS[i].par; rd_in_be = VECS[i].be; rd_out_ready = 1'b0;
      #1;
      check("R1 write parity", 32'(wr_out_par), 32'(VECS[i].wpar));
      check("R4 read error", 32'(rd_out_err), 32'(VECS[i].err));
      check("R4 read data", rd_out_data, VECS[i].data);
    end
    @(negedge clk);
    wr_in_valid = 1'b0; rd_in_valid = 1'b0;
    // table ran with ready low: erroring rows must not have captured (R9)
    for (int b = 0; b < 4; b++) peek_bank("R9 stalled no capture", 2'(b), 1'b0, '0);

    // R9: handshake pass-through
    wr_in_valid = 1'b1; wr_out_ready = 1'b0; rd_in_valid = 1'b0; rd_out_ready = 1'b1;
    #1;
    check("R9 wr valid", 32'(wr_out_valid), 32'd1);
    check("R9 wr ready", 32'(wr_in_ready), 32'd0);
    check("R9 rd valid", 32'(rd_out_valid), 32'd0);
    check("R9 rd ready", 32'(rd_in_ready), 32'd1);
    wr_in_valid = 1'b0; rd_out_ready = 1'b0;

    par_mode = 2'd1;
    // R9: stalled erroring beat in bank 0
    err_beat(2'd0, 16'h0BAD, 1'b0);
    peek_bank("R9", 2'd0, 1'b0, '0);

    // R6: capture into bank 1 only
    err_beat(2'd1, 16'h1234, 1'b1);
    peek_bank("R6", 2'd1, 1'b1, 16'h1234);
    peek_bank("R6 other bank", 2'd0, 1'b0, '0);

    // R7: second error keeps the first address
    err_beat(2'd1, 16'h5678, 1'b1);
    peek_bank("R7", 2'd1, 1'b1, 16'h1234);

    // R8: clear alone, then clear with simultaneous capture
    @(negedge clk);
    err_clr = 1'b1; err_clr_bank = 2'd1;
    @(negedge clk);
    err_clr = 1'b0;
    err_sel = 2'd1; #1;
    check("R8 cleared", 32'(err_rd_valid), 32'd0);
    @(negedge clk);
    err_clr = 1'b1; err_clr_bank = 2'd1;
    rd_in_valid = 1'b1; rd_in_bank = 2'd1; rd_in_addr = 16'h9ABC;
    rd_in_data = 32'h01030F07; rd_in_par = 4'b1000; rd_in_be = 4'hF; rd_out_ready = 1'b1;
    @(negedge clk);
    err_clr = 1'b0; rd_in_valid = 1'b0; rd_out_ready = 1'b0;
    peek_bank("R8 clear plus capture", 2'd1, 1'b1, 16'h9ABC);

    // R2: no-parity mode captures nothing
    par_mode = 2'd0;
    err_beat(2'd2, 16'h2222, 1'b1);
    peek_bank("R2 no capture", 2'd2, 1'b0, '0);

    // R3: non-SRAM bank captures nothing
    par_mode = 2'd1;
    err_beat(2'd3, 16'h3333, 1'b1);
    peek_bank("R3 no capture", 2'd3, 1'b0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule